// File: doc/BRIEF.md
# ECC Error Reporting Register Block

This block sits next to the ECC path of an SDRAM controller and gives software a small register window onto memory error events. An external SECDED decoder pulses one of three event inputs (correctable single-bit error, uncorrectable double-bit error, dropped correction) and supplies the failing address for each class. The block keeps sticky status flags, one saturating counter per error class and a single captured failing address. It drives one level interrupt, which software can enable, mask per error class and clear.

A configuration register holds the ECC enable and correction enable bits, and two one-shot injection flags. The write path reads these flags and corrupts the next stored word with one or two flipped bits. A flag clears itself when the write path reports that a word has been stored. A later read of that word comes back through the decoder as the matching error event. Register access uses a simple 32-bit port: a write strobe with address and data, and a combinational read-data output selected by the address.

Top module: `ecc_err_regs`

## Requirements
- R1: The configuration register at offset 0x00 stores bit 10 (ECC enable), bit 11 (correction enable), bit 13 (single-flip injection) and bit 14 (double-flip injection). All other bits read 0. `ecc_active` is 1 only when bits 10 and 11 are both set.
- R2: `inj_one_bit` is 1 while bit 13 is set and bit 14 is clear. `inj_two_bit` is 1 while bit 14 is set, so double takes priority. Both flags clear in the cycle after a `data_wr_stb` pulse, unless the configuration register is written in that same cycle.
- R3: The status register at offset 0x38 sets bit 2 on a single-bit event, bit 3 on a double-bit event and bit 4 on a dropped correction. These bits stay set until a clear. All other bits read 0.
- R4: The single-bit counter (offset 0x40, bits 3:0) and the double-bit counter (offset 0x44, bits 3:0) each add one per event of their class. They hold at 15 instead of wrapping.
- R5: The 32-bit error address at offset 0x48 takes the failing address of the first single-bit or double-bit event after reset or after a clear. Later events leave it unchanged until the next clear.
- R6: When a single-bit and a double-bit event arrive in the same cycle and no address is held yet, the double-bit address is captured.
- R7: The interrupt register at offset 0x3C holds bit 0 (enable), bit 1 (mask single-bit), bit 2 (mask double-bit) and bit 3 (mask dropped correction). `irq` is the enable ANDed with the OR of every status flag whose mask bit is 0.
- R8: Writing 0x3C with bit 4 set clears the status flags, both counters and the address hold. Bit 0 of the same write becomes the new enable, so clear-with-enable leaves the interrupt enabled and clear alone leaves it disabled. Bit 4 always reads 0. An event in the same cycle as a clear is recorded after the clear.
- R9: The interface width register at offset 0x30 reads the data width plus 8 check bits: 40 for a 32-bit path, 24 for a 16-bit path.
- R10: After reset every register reads 0 except the width register, and `irq`, `ecc_active` and both injection outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ev_sbe | input | 1 | Single-bit error event pulse from the decoder |
| ev_dbe | input | 1 | Double-bit error event pulse from the decoder |
| ev_drop | input | 1 | Dropped-correction event pulse |
| sbe_addr | input | ADDR_W | Failing address of the single-bit event |
| dbe_addr | input | ADDR_W | Failing address of the double-bit event |
| data_wr_stb | input | 1 | Write path has stored a data word |
| ecc_active | output | 1 | ECC and correction both enabled |
| inj_one_bit | output | 1 | Corrupt next stored word with one flip |
| inj_two_bit | output | 1 | Corrupt next stored word with two flips |
| irq | output | 1 | Level interrupt |

## Verification
Events are applied alone, two classes in one cycle, repeated past the counter limit, and coincident with a clear write. These patterns separate first-event address capture from later events, double-bit address priority, saturation from wraparound, and clear-then-record ordering. The interrupt is observed under each combination of enable and per-class masks, which shows whether each flag's contribution is gated separately. Injection flags are set singly and together, then consumed by a store strobe, to show priority and one-shot clearing.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;

    localparam int unsigned REG_AW = 8;

    // register offsets
    localparam logic [REG_AW-1:0] OFS_CFG   = 8'h00;
    localparam logic [REG_AW-1:0] OFS_IFW   = 8'h30;
    localparam logic [REG_AW-1:0] OFS_STAT  = 8'h38;
    localparam logic [REG_AW-1:0] OFS_INTR  = 8'h3C;
    localparam logic [REG_AW-1:0] OFS_SCNT  = 8'h40;
    localparam logic [REG_AW-1:0] OFS_DCNT  = 8'h44;
    localparam logic [REG_AW-1:0] OFS_EADDR = 8'h48;

    // configuration bits
    localparam int CB_ECC  = 10;
    localparam int CB_CORR = 11;
    localparam int CB_INJ1 = 13;
    localparam int CB_INJ2 = 14;

    // status bits
    localparam int SB_SBE  = 2;
    localparam int SB_DBE  = 3;
    localparam int SB_DROP = 4;

    // interrupt control bits
    localparam int IB_EN    = 0;
    localparam int IB_MSBE  = 1;
    localparam int IB_MDBE  = 2;
    localparam int IB_MDROP = 3;
    localparam int IB_CLR   = 4;

    typedef struct packed {
        logic ecc_en;
        logic corr_en;
        logic inj_one;
        logic inj_two;
    } ecc_cfg_t;

    typedef struct packed {
        logic drop;
        logic dbe;
        logic sbe;
    } err_flags_t;

    typedef enum logic [1:0] {
        INJ_NONE = 2'd0,
        INJ_ONE  = 2'd1,
        INJ_TWO  = 2'd2
    } inj_kind_t;

    function automatic inj_kind_t pick_inj(input ecc_cfg_t c);
        if (c.inj_two)      return INJ_TWO;
        else if (c.inj_one) return INJ_ONE;
        else                return INJ_NONE;
    endfunction

endpackage

// File: rtl/ecc_cfg_reg.sv
module ecc_cfg_reg
    import ecc_err_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [31:0] wdata,
    input  logic        data_wr_stb,
    output ecc_cfg_t    cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr) begin
            cfg.ecc_en  <= wdata[CB_ECC];
            cfg.corr_en <= wdata[CB_CORR];
            cfg.inj_one <= wdata[CB_INJ1];
            cfg.inj_two <= wdata[CB_INJ2];
        end else if (data_wr_stb) begin
            // flags are consumed by the stored word
            cfg.inj_one <= 1'b0;
            cfg.inj_two <= 1'b0;
        end
    end

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
    import ecc_err_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  err_flags_t           ev,
    input  logic [ADDR_W-1:0]    sbe_addr,
    input  logic [ADDR_W-1:0]    dbe_addr,
    output err_flags_t           flags,
    output logic [2*CNT_W-1:0]   cnt_bus,
    output logic [ADDR_W-1:0]    cap_addr,
    output logic                 locked
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // sticky flags; a clear restarts from the current events
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= clr ? ev : (flags | ev);
    end

    // one saturating counter per error class: 0 = single, 1 = double
    for (genvar g = 0; g < 2; g++) begin : g_cnt
        logic [CNT_W-1:0] q;
        logic [CNT_W-1:0] base;
        logic             hit;

        assign hit  = (g == 0) ? ev.sbe : ev.dbe;
        assign base = clr ? '0 : q;

        always_ff @(posedge clk) begin
            if (rst)                       q <= '0;
            else if (hit && base != CNT_MAX) q <= base + 1'b1;
            else                           q <= base;
        end

        assign cnt_bus[g*CNT_W +: CNT_W] = q;
    end

    // first-event address capture, double-bit wins a tie
    logic lock_base;
    assign lock_base = clr ? 1'b0 : locked;

    always_ff @(posedge clk) begin
        if (rst) begin
            locked   <= 1'b0;
            cap_addr <= '0;
        end else if (!lock_base && (ev.sbe || ev.dbe)) begin
            locked   <= 1'b1;
            cap_addr <= ev.dbe ? dbe_addr : sbe_addr;
        end else begin
            locked   <= lock_base;
        end
    end

endmodule

// File: rtl/ecc_irq_ctl.sv
module ecc_irq_ctl
    import ecc_err_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [31:0] wdata,
    input  err_flags_t  flags,
    output logic        en,
    output err_flags_t  mask,
    output logic        clr,
    output logic        irq
);

    assign clr = wr && wdata[IB_CLR];

    always_ff @(posedge clk) begin
        if (rst) begin
            en   <= 1'b0;
            mask <= '0;
        end else if (wr) begin
            en        <= wdata[IB_EN];
            mask.sbe  <= wdata[IB_MSBE];
            mask.dbe  <= wdata[IB_MDBE];
            mask.drop <= wdata[IB_MDROP];
        end
    end

    assign irq = en && |(flags & ~mask);

endmodule

// File: rtl/ecc_err_regs.sv
module ecc_err_regs
    import ecc_err_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [REG_AW-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic                 ev_sbe,
    input  logic                 ev_dbe,
    input  logic                 ev_drop,
    input  logic [ADDR_W-1:0]    sbe_addr,
    input  logic [ADDR_W-1:0]    dbe_addr,
    input  logic                 data_wr_stb,
    output logic                 ecc_active,
    output logic                 inj_one_bit,
    output logic                 inj_two_bit,
    output logic                 irq
);

    localparam int unsigned  CHECK_W  = 8;
    localparam logic [31:0]  IFW_CODE = 32'(DATA_W + CHECK_W);

    ecc_cfg_t           cfg;
    err_flags_t         ev;
    err_flags_t         flag_q;
    err_flags_t         intr_mask;
    logic               intr_en;
    logic               clr_now;
    logic               addr_locked;
    logic [2*CNT_W-1:0] cnt_bus;
    logic [CNT_W-1:0]   sbe_cnt;
    logic [CNT_W-1:0]   dbe_cnt;
    logic [ADDR_W-1:0]  cap_addr;
    logic               cfg_wr;
    logic               intr_wr;
    inj_kind_t          inj_kind;

    assign cfg_wr  = bus_wr && (bus_addr == OFS_CFG);
    assign intr_wr = bus_wr && (bus_addr == OFS_INTR);

    assign ev.sbe  = ev_sbe;
    assign ev.dbe  = ev_dbe;
    assign ev.drop = ev_drop;

    ecc_cfg_reg u_cfg (
        .clk         (clk),
        .rst         (rst),
        .wr          (cfg_wr),
        .wdata       (bus_wdata),
        .data_wr_stb (data_wr_stb),
        .cfg         (cfg)
    );

    ecc_err_log #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_log (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr_now),
        .ev       (ev),
        .sbe_addr (sbe_addr),
        .dbe_addr (dbe_addr),
        .flags    (flag_q),
        .cnt_bus  (cnt_bus),
        .cap_addr (cap_addr),
        .locked   (addr_locked)
    );

    ecc_irq_ctl u_irq (
        .clk   (clk),
        .rst   (rst),
        .wr    (intr_wr),
        .wdata (bus_wdata),
        .flags (flag_q),
        .en    (intr_en),
        .mask  (intr_mask),
        .clr   (clr_now),
        .irq   (irq)
    );

    assign sbe_cnt = cnt_bus[0 +: CNT_W];
    assign dbe_cnt = cnt_bus[CNT_W +: CNT_W];

    assign inj_kind    = pick_inj(cfg);
    assign inj_one_bit = (inj_kind == INJ_ONE);
    assign inj_two_bit = (inj_kind == INJ_TWO);
    assign ecc_active  = cfg.ecc_en && cfg.corr_en;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CFG: begin
                bus_rdata[CB_ECC]  = cfg.ecc_en;
                bus_rdata[CB_CORR] = cfg.corr_en;
                bus_rdata[CB_INJ1] = cfg.inj_one;
                bus_rdata[CB_INJ2] = cfg.inj_two;
            end
            OFS_IFW:   bus_rdata = IFW_CODE;
            OFS_STAT: begin
                bus_rdata[SB_SBE]  = flag_q.sbe;
                bus_rdata[SB_DBE]  = flag_q.dbe;
                bus_rdata[SB_DROP] = flag_q.drop;
            end
            OFS_INTR: begin
                bus_rdata[IB_EN]    = intr_en;
                bus_rdata[IB_MSBE]  = intr_mask.sbe;
                bus_rdata[IB_MDBE]  = intr_mask.dbe;
                bus_rdata[IB_MDROP] = intr_mask.drop;
            end
            OFS_SCNT:  bus_rdata[CNT_W-1:0]  = sbe_cnt;
            OFS_DCNT:  bus_rdata[CNT_W-1:0]  = dbe_cnt;
            OFS_EADDR: bus_rdata[ADDR_W-1:0] = cap_addr;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ecc_err_regs_chk.sv
module ecc_err_regs_chk
    import ecc_err_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_wr,
    input logic [REG_AW-1:0]  bus_addr,
    input logic [31:0]        bus_wdata,
    input logic               ev_sbe,
    input logic               ev_dbe,
    input logic               ev_drop,
    input logic               data_wr_stb,
    input logic               inj_one_bit,
    input logic               inj_two_bit,
    input logic               irq,
    input logic               intr_en,
    input logic [2:0]         flag_bits,
    input logic [CNT_W-1:0]   sbe_cnt,
    input logic [ADDR_W-1:0]  cap_addr,
    input logic               addr_locked
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic clr_wr;
    logic cfg_wr;
    assign clr_wr = bus_wr && (bus_addr == OFS_INTR) && bus_wdata[IB_CLR];
    assign cfg_wr = bus_wr && (bus_addr == OFS_CFG);

    // R7
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (intr_en && flag_bits != 3'b000));

    // R4
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (sbe_cnt == CNT_MAX && !clr_wr) |=> sbe_cnt == CNT_MAX);

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_locked && !clr_wr) |=> $stable(cap_addr));

    // R8
    clear_all_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !ev_sbe && !ev_dbe && !ev_drop) |=> (flag_bits == 3'b000 && sbe_cnt == '0));

    // R2
    inj_consume_chk: assert property (@(posedge clk) disable iff (rst)
        (data_wr_stb && !cfg_wr) |=> (!inj_one_bit && !inj_two_bit));

    // R2
    inj_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({inj_one_bit, inj_two_bit}));

    // R3
    sbe_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ev_sbe |=> flag_bits[0]);

endmodule

bind ecc_err_regs ecc_err_regs_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .ev_sbe      (ev_sbe),
    .ev_dbe      (ev_dbe),
    .ev_drop     (ev_drop),
    .data_wr_stb (data_wr_stb),
    .inj_one_bit (inj_one_bit),
    .inj_two_bit (inj_two_bit),
    .irq         (irq),
    .intr_en     (intr_en),
    .flag_bits   (flag_q),
    .sbe_cnt     (sbe_cnt),
    .cap_addr    (cap_addr),
    .addr_locked (addr_locked)
);

// File: tb/ecc_err_regs_tb_top.sv
module ecc_err_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ev_sbe = 1'b0;
    logic        ev_dbe = 1'b0;
    logic        ev_drop = 1'b0;
    logic [31:0] sbe_addr = '0;
    logic [31:0] dbe_addr = '0;
    logic        data_wr_stb = 1'b0;
    logic        ecc_active;
    logic        inj_one_bit;
    logic        inj_two_bit;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ecc_err_regs dut_i (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .ev_sbe      (ev_sbe),
        .ev_dbe      (ev_dbe),
        .ev_drop     (ev_drop),
        .sbe_addr    (sbe_addr),
        .dbe_addr    (dbe_addr),
        .data_wr_stb (data_wr_stb),
        .ecc_active  (ecc_active),
        .inj_one_bit (inj_one_bit),
        .inj_two_bit (inj_two_bit),
        .irq         (irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic fire(input logic s, input logic d, input logic dr,
                        input logic [31:0] sa, input logic [31:0] da);
        @(negedge clk);
        ev_sbe = s; ev_dbe = d; ev_drop = dr; sbe_addr = sa; dbe_addr = da;
        @(negedge clk);
        ev_sbe = 1'b0; ev_dbe = 1'b0; ev_drop = 1'b0;
    endtask

    task automatic store_word();
        @(negedge clk);
        data_wr_stb = 1'b1;
        @(negedge clk);
        data_wr_stb = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        reg_rd(8'h00, r); check(r, 32'h0, "R10 cfg after reset");
        reg_rd(8'h38, r); check(r, 32'h0, "R10 status after reset");
        reg_rd(8'h40, r); check(r, 32'h0, "R10 sbe count after reset");
        reg_rd(8'h48, r); check(r, 32'h0, "R10 address after reset");
        check({31'b0, irq}, 32'h0, "R10 irq after reset");
        check({31'b0, ecc_active}, 32'h0, "R10 ecc_active after reset");
        reg_rd(8'h30, r); check(r, 32'd40, "R9 width code 32-bit path");
    endtask

    task automatic t_cfg();
        logic [31:0] r;
        reg_wr(8'h00, 32'hFFFF_FFFF);
        reg_rd(8'h00, r); check(r, 32'h0000_6C00, "R1 cfg readback all ones");
        check({31'b0, ecc_active}, 32'h1, "R1 ecc_active both bits");
        check({30'b0, inj_two_bit, inj_one_bit}, 32'h2, "R2 double has priority");
        reg_wr(8'h00, 32'h0000_0400);
        reg_rd(8'h00, r); check(r, 32'h0000_0400, "R1 cfg ecc only");
        check({31'b0, ecc_active}, 32'h0, "R1 ecc_active needs correction bit");
    endtask

    task automatic t_inject();
        logic [31:0] r;
        reg_wr(8'h00, 32'h0000_2C00);
        check({30'b0, inj_two_bit, inj_one_bit}, 32'h1, "R2 single flip armed");
        store_word();
        reg_rd(8'h00, r); check(r, 32'h0000_0C00, "R2 single flag consumed");
        check({30'b0, inj_two_bit, inj_one_bit}, 32'h0, "R2 outputs idle after store");
        reg_wr(8'h00, 32'h0000_4C00);
        check({30'b0, inj_two_bit, inj_one_bit}, 32'h2, "R2 double flip armed");
        store_word();
        reg_rd(8'h00, r); check(r, 32'h0000_0C00, "R2 double flag consumed");
    endtask

    task automatic t_events();
        logic [31:0] r;
        reg_wr(8'h3C, 32'h11);
        fire(1'b1, 1'b0, 1'b0, 32'h1000_0040, 32'h0);
        reg_rd(8'h38, r); check(r, 32'h4, "R3 single flag");
        reg_rd(8'h40, r); check(r, 32'h1, "R4 single count one");
        reg_rd(8'h48, r); check(r, 32'h1000_0040, "R5 first address captured");
        check({31'b0, irq}, 32'h1, "R7 irq unmasked single");
        fire(1'b0, 1'b1, 1'b0, 32'h0, 32'h2222_0000);
        reg_rd(8'h38, r); check(r, 32'hC, "R3 flags accumulate");
        reg_rd(8'h44, r); check(r, 32'h1, "R4 double count one");
        reg_rd(8'h48, r); check(r, 32'h1000_0040, "R5 address held");
    endtask

    task automatic t_mask();
        logic [31:0] r;
        reg_wr(8'h3C, 32'h07);
        reg_rd(8'h3C, r); check(r, 32'h7, "R7 intr readback");
        check({31'b0, irq}, 32'h0, "R7 masked classes silent");
        fire(1'b0, 1'b0, 1'b1, 32'h0, 32'h0);
        reg_rd(8'h38, r); check(r, 32'h1C, "R3 drop flag");
        check({31'b0, irq}, 32'h1, "R7 unmasked drop raises irq");
        reg_wr(8'h3C, 32'h0F);
        check({31'b0, irq}, 32'h0, "R7 all masked");
    endtask

    task automatic t_clear_en();
        logic [31:0] r;
        reg_wr(8'h3C, 32'h11);
        reg_rd(8'h38, r); check(r, 32'h0, "R8 status cleared");
        reg_rd(8'h40, r); check(r, 32'h0, "R8 single count cleared");
        reg_rd(8'h44, r); check(r, 32'h0, "R8 double count cleared");
        reg_rd(8'h3C, r); check(r, 32'h1, "R8 enable kept, clear reads 0");
        check({31'b0, irq}, 32'h0, "R8 irq dropped");
    endtask

    task automatic t_both();
        logic [31:0] r;
        fire(1'b1, 1'b1, 1'b0, 32'hAAAA_0000, 32'hBBBB_0000);
        reg_rd(8'h48, r); check(r, 32'hBBBB_0000, "R6 double address wins");
        reg_rd(8'h40, r); check(r, 32'h1, "R4 single count in tie");
        reg_rd(8'h44, r); check(r, 32'h1, "R4 double count in tie");
    endtask

    task automatic t_sat();
        logic [31:0] r;
        reg_wr(8'h3C, 32'h11);
        for (int i = 0; i < 20; i++) fire(1'b1, 1'b0, 1'b0, 32'h100 + i, 32'h0);
        reg_rd(8'h40, r); check(r, 32'd15, "R4 saturates at 15");
        reg_rd(8'h44, r); check(r, 32'h0, "R4 double untouched");
        reg_rd(8'h48, r); check(r, 32'h100, "R5 first of burst kept");
    endtask

    task automatic t_clear_only();
        logic [31:0] r;
        reg_wr(8'h3C, 32'h10);
        reg_rd(8'h3C, r); check(r, 32'h0, "R8 clear alone disables");
        reg_rd(8'h38, r); check(r, 32'h0, "R8 status cleared alone");
        fire(1'b0, 1'b1, 1'b0, 32'h0, 32'h3333_0000);
        reg_rd(8'h38, r); check(r, 32'h8, "R3 flag while disabled");
        check({31'b0, irq}, 32'h0, "R7 disabled irq low");
        reg_rd(8'h48, r); check(r, 32'h3333_0000, "R5 capture after clear");
        // clear and event in the same cycle
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h3C; bus_wdata = 32'h11;
        ev_sbe = 1'b1; sbe_addr = 32'h4444_0000;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; ev_sbe = 1'b0;
        reg_rd(8'h38, r); check(r, 32'h4, "R8 coincident event recorded");
        reg_rd(8'h40, r); check(r, 32'h1, "R8 coincident count");
        reg_rd(8'h48, r); check(r, 32'h4444_0000, "R8 coincident address");
        check({31'b0, irq}, 32'h1, "R8 irq after coincident event");
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_cfg();
        t_inject();
        t_events();
        t_mask();
        t_clear_en();
        t_both();
        t_sat();
        t_clear_only();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule